// File: doc/BRIEF.md
# Occupancy-Driven Threshold Tuning Controller

This block searches for the threshold setting at which a fixed test charge, sized to equal the wanted threshold, produces a hit on half of its injections. After a start request it places a setting on its output, asks the surrounding logic for one burst of injections and waits for the hit count of that burst. It compares the count against half of the burst length without a divider, by doubling the count. With too few hits it lowers the setting, with too many it raises it, and on an exact half it leaves it alone.

The step size begins at half of the target field's range and is halved after every iteration. The search therefore ends after as many iterations as the field has bits, and the last step is one code. Results are clamped to the field, so an adjustment never wraps. The final value is latched on a separate output, and a one-cycle done pulse marks it valid. A mode input, sampled at start, chooses the target. In global mode the target is a coarse/fine pair packed into one word, coarse in the upper bits. In trim mode it is a narrower per-pixel trim value in the low bits.

Top module: `thr_tuner`

## Requirements
- R1: After reset, `setting` and `tuned` are zero and `busy`, `done` and `burst_req` are low.
- R2: A `start` seen while idle samples `trim_sel` and loads `setting` with the midpoint 2^(W-1) of the chosen field. W is TRIM_W (5) in trim mode (`trim_sel`=1) and COARSE_W+FINE_W (13) in global mode. `busy` is high from the next cycle.
- R3: In every iteration `burst_req` is high for exactly one cycle while `setting` is held. The block then waits for `hit_valid`, however many cycles that takes.
- R4: When twice `hit_count` is less than INJ_COUNT (100), `setting` decreases by the current step.
- R5: When twice `hit_count` is greater than INJ_COUNT, `setting` increases by the current step.
- R6: When twice `hit_count` equals INJ_COUNT, `setting` is unchanged for that iteration.
- R7: The step starts at 2^(W-1) and halves after each iteration, and exactly W iterations (W burst requests) are run.
- R8: Adjusted values are clamped to the range 0 to 2^W-1 of the chosen field.
- R9: `done` is a one-cycle pulse in the cycle after the final hit count is accepted. In that cycle `tuned` and `setting` both equal the final value, and `busy` is low.
- R10: `start` while busy and `hit_valid` while not waiting for a count have no effect on `setting` or on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tuning run (honoured only while idle) |
| trim_sel | input | 1 | 1 = per-pixel trim field, 0 = global coarse/fine pair |
| burst_req | output | 1 | One-cycle request for one burst of injections |
| hit_valid | input | 1 | Hit count of the requested burst is present |
| hit_count | input | 7 | Number of hits in the burst (0..INJ_COUNT) |
| setting | output | 13 | Setting applied while the burst runs; coarse in [12:8], fine in [7:0], trim in [4:0] |
| tuned | output | 13 | Latched final setting |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: `tuned` is valid |

## Verification
The assertions assume that `hit_count` never exceeds INJ_COUNT whenever `hit_valid` is high. They also assume that each count answers a single burst request. The bench's model detector produces its counts from the current setting. In every mode it picks them between zero and the burst length, and it asserts `hit_valid` only after a request has been seen, with the exception of the deliberate stray pulses used to test R10. The random detector keeps each count on the correct side of half the burst, so every decision stays well defined.

// File: rtl/thr_tuner_pkg.sv
package thr_tuner_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_APPLY = 2'd1,
    TS_WAIT  = 2'd2
  } tune_state_e;
endpackage

// File: rtl/tune_sequencer.sv
module tune_sequencer
  import thr_tuner_pkg::*;
#(
  parameter int SET_W  = 13,
  parameter int TRIM_W = 5,
  localparam int ITER_W = $clog2(SET_W + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        trim_sel,
  input  logic        hit_valid,
  output tune_state_e state,
  output logic        mode_trim,
  output logic        load,
  output logic        update,
  output logic        last_iter
);
  tune_state_e       st_q, st_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic              mode_q, mode_d;
  logic [ITER_W-1:0] num_iter;

  assign num_iter  = mode_q ? ITER_W'(TRIM_W) : ITER_W'(SET_W);
  assign load      = (st_q == TS_IDLE) && start;
  assign update    = (st_q == TS_WAIT) && hit_valid;
  assign last_iter = (iter_q == num_iter - ITER_W'(1));

  always_comb begin
    st_d   = st_q;
    iter_d = iter_q;
    mode_d = mode_q;
    unique case (st_q)
      TS_IDLE: if (start) begin
        st_d   = TS_APPLY;
        iter_d = '0;
        mode_d = trim_sel;
      end
      TS_APPLY: st_d = TS_WAIT;
      TS_WAIT: if (hit_valid) begin
        iter_d = iter_q + ITER_W'(1);
        st_d   = last_iter ? TS_IDLE : TS_APPLY;
      end
      default: st_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_IDLE;
      iter_q <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      iter_q <= iter_d;
      mode_q <= mode_d;
    end
  end

  assign state     = st_q;
  assign mode_trim = mode_q;
endmodule

// File: rtl/tune_step_gen.sv
module tune_step_gen #(
  parameter int SET_W  = 13,
  parameter int TRIM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             trim_sel,
  input  logic             update,
  output logic [SET_W-1:0] step,
  output logic [SET_W-1:0] midpoint
);
  localparam logic [SET_W-1:0] HALF_GLOBAL = SET_W'(1) << (SET_W - 1);
  localparam logic [SET_W-1:0] HALF_TRIM   = SET_W'(1) << (TRIM_W - 1);

  logic [SET_W-1:0] step_q, step_d;

  assign midpoint = trim_sel ? HALF_TRIM : HALF_GLOBAL;

  always_comb begin
    step_d = step_q;
    if (load)        step_d = midpoint;
    else if (update) step_d = step_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else if (load || update) step_q <= step_d;
  end

  assign step = step_q;
endmodule

// File: rtl/tune_adjust.sv
module tune_adjust #(
  parameter int SET_W     = 13,
  parameter int INJ_COUNT = 100,
  localparam int HIT_W    = $clog2(INJ_COUNT + 1)
) (
  input  logic [SET_W-1:0] cur,
  input  logic [SET_W-1:0] step,
  input  logic [SET_W-1:0] field_max,
  input  logic [HIT_W-1:0] hit_count,
  output logic [SET_W-1:0] nxt
);
  localparam logic [HIT_W:0] INJ_V = (HIT_W + 1)'(INJ_COUNT);

  logic [HIT_W:0] twice;
  logic           too_low, too_high;
  logic [SET_W:0] sum;
  logic [SET_W:0] ext_max;

  assign twice    = {hit_count, 1'b0};
  assign too_low  = twice < INJ_V;
  assign too_high = twice > INJ_V;
  assign sum      = {1'b0, cur} + {1'b0, step};
  assign ext_max  = {1'b0, field_max};

  always_comb begin
    nxt = cur;
    if (too_high) begin
      nxt = (sum > ext_max) ? field_max : sum[SET_W-1:0];
    end else if (too_low) begin
      nxt = (step > cur) ? '0 : cur - step;
    end
  end
endmodule

// File: rtl/thr_tuner.sv
module thr_tuner
  import thr_tuner_pkg::*;
#(
  parameter int COARSE_W  = 5,
  parameter int FINE_W    = 8,
  parameter int TRIM_W    = 5,
  parameter int INJ_COUNT = 100,
  localparam int SET_W    = COARSE_W + FINE_W,
  localparam int HIT_W    = $clog2(INJ_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             trim_sel,
  output logic             burst_req,
  input  logic             hit_valid,
  input  logic [HIT_W-1:0] hit_count,
  output logic [SET_W-1:0] setting,
  output logic [SET_W-1:0] tuned,
  output logic             busy,
  output logic             done
);
  localparam logic [SET_W-1:0] MAX_GLOBAL = {SET_W{1'b1}};
  localparam logic [SET_W-1:0] MAX_TRIM   = (SET_W'(1) << TRIM_W) - SET_W'(1);

  tune_state_e      st;
  logic             trim_q, load, update, last_iter;
  logic [SET_W-1:0] step, midpoint, field_max, adj;
  logic [SET_W-1:0] set_q, set_d, tuned_q, tuned_d;
  logic             done_q, done_d;
  logic             in_wait;

  tune_sequencer #(.SET_W(SET_W), .TRIM_W(TRIM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .trim_sel(trim_sel),
    .hit_valid(hit_valid), .state(st), .mode_trim(trim_q),
    .load(load), .update(update), .last_iter(last_iter)
  );

  tune_step_gen #(.SET_W(SET_W), .TRIM_W(TRIM_W)) u_step (
    .clk(clk), .rst_n(rst_n), .load(load), .trim_sel(trim_sel),
    .update(update), .step(step), .midpoint(midpoint)
  );

  assign field_max = trim_q ? MAX_TRIM : MAX_GLOBAL;

  tune_adjust #(.SET_W(SET_W), .INJ_COUNT(INJ_COUNT)) u_adj (
    .cur(set_q), .step(step), .field_max(field_max),
    .hit_count(hit_count), .nxt(adj)
  );

  always_comb begin
    set_d   = set_q;
    tuned_d = tuned_q;
    done_d  = update && last_iter;
    if (load)        set_d = midpoint;
    else if (update) set_d = adj;
    if (update && last_iter) tuned_d = adj;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q   <= '0;
      tuned_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (load || update)        set_q   <= set_d;
      if (update && last_iter)   tuned_q <= tuned_d;
      done_q <= done_d;
    end
  end

  assign in_wait   = (st == TS_WAIT);
  assign burst_req = (st == TS_APPLY);
  assign busy      = (st != TS_IDLE);
  assign setting   = set_q;
  assign tuned     = tuned_q;
  assign done      = done_q;
endmodule

// File: rtl/thr_tuner_chk.sv
module thr_tuner_chk #(
  parameter int SET_W     = 13,
  parameter int TRIM_W    = 5,
  parameter int INJ_COUNT = 100,
  parameter int HIT_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             burst_req,
  input logic             hit_valid,
  input logic [HIT_W-1:0] hit_count,
  input logic [SET_W-1:0] setting,
  input logic [SET_W-1:0] tuned,
  input logic             busy,
  input logic             done,
  input logic             mode_trim,
  input logic             in_wait
);
  localparam logic [HIT_W:0] INJ_V = (HIT_W + 1)'(INJ_COUNT);
  localparam logic [SET_W:0] TRIM_LIM = (SET_W + 1)'(1) << TRIM_W;

  logic [HIT_W:0] twice;
  assign twice = {hit_count, 1'b0};

  assert_hit_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> ({1'b0, hit_count} <= INJ_V));
  assert_burst_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |=> !burst_req);
  assert_burst_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> busy);
  assert_low_decrease_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && hit_valid && twice < INJ_V) |=> setting <= $past(setting));
  assert_high_increase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && hit_valid && twice > INJ_V) |=> setting >= $past(setting));
  assert_half_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && hit_valid && twice == INJ_V) |=> $stable(setting));
  assert_trim_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_trim) |-> ({1'b0, setting} < TRIM_LIM));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tuned == setting && !busy));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(setting));
endmodule

bind thr_tuner thr_tuner_chk #(
  .SET_W(SET_W), .TRIM_W(TRIM_W), .INJ_COUNT(INJ_COUNT), .HIT_W(HIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .burst_req(burst_req),
  .hit_valid(hit_valid), .hit_count(hit_count), .setting(setting),
  .tuned(tuned), .busy(busy), .done(done), .mode_trim(trim_q),
  .in_wait(in_wait)
);

// File: tb/sim_thr_tuner.sv
module sim_thr_tuner;
  localparam int CLK_PERIOD = 10;
  localparam int SW   = 13;
  localparam int TW   = 5;
  localparam int INJ  = 100;
  localparam int HW   = 7;
  localparam int WDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          trim_sel = 1'b0;
  logic          hit_valid = 1'b0;
  logic [HW-1:0] hit_count = '0;
  logic          burst_req, busy, done;
  logic [SW-1:0] setting, tuned;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thr_tuner u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .trim_sel(trim_sel),
    .burst_req(burst_req), .hit_valid(hit_valid), .hit_count(hit_count),
    .setting(setting), .tuned(tuned), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected next setting from the requirements (R4, R5, R6, R8)
  function automatic int model_next(input int cur, input int stp, input int hits, input int maxv);
    if (2 * hits > INJ) return (cur + stp > maxv) ? maxv : cur + stp;
    if (2 * hits < INJ) return (stp > cur) ? 0 : cur - stp;
    return cur;
  endfunction

  // model detector: kind 0 sharp, 1 random on the right side, 2 always half
  function automatic int respond(input int cur, input int thr, input int kind);
    if (kind == 2) return INJ / 2;
    if (cur < thr) return (kind == 1) ? (INJ / 2 + 1 + int'($urandom % (INJ / 2))) : INJ;
    if (cur > thr) return (kind == 1) ? int'($urandom % (INJ / 2)) : 0;
    return INJ / 2;
  endfunction

  task automatic run_tune(input bit trim, input int thr, input int kind,
                          input bit stray, output int final_val);
    int w, maxv, expv, stp, hits, nreq;
    w    = trim ? TW : SW;
    maxv = (1 << w) - 1;
    expv = 1 << (w - 1);
    stp  = 1 << (w - 1);
    nreq = 0;
    @(negedge clk);
    start = 1'b1; trim_sel = trim;
    @(negedge clk);
    start = 1'b0;
    chk(setting == SW'(expv) && busy, "R2 midpoint load", int'(setting), expv);
    for (int it = 0; it < w; it++) begin
      for (int p = 0; p < 20 && !burst_req; p++) @(negedge clk);
      if (burst_req) nreq++;
      chk(setting == SW'(expv), "R3 setting held at request", int'(setting), expv);
      hits = respond(expv, thr, kind);
      @(negedge clk);
      chk(!burst_req, "R3 request lasts one cycle", int'(burst_req), 0);
      if (stray && it == 1) start = 1'b1;
      hit_valid = 1'b1; hit_count = HW'(hits);
      @(negedge clk);
      hit_valid = 1'b0; start = 1'b0;
      expv = model_next(expv, stp, hits, maxv);
      stp  = stp / 2;
      if (2 * hits < INJ)      chk(setting == SW'(expv), "R4 decrease", int'(setting), expv);
      else if (2 * hits > INJ) chk(setting == SW'(expv), "R5 increase", int'(setting), expv);
      else                     chk(setting == SW'(expv), "R6 hold on half", int'(setting), expv);
    end
    chk(nreq == w, "R7 iteration count", nreq, w);
    chk(done && tuned == SW'(expv) && !busy, "R9 done with final value", int'(tuned), expv);
    @(negedge clk);
    chk(!done, "R9 done is one cycle", int'(done), 0);
    final_val = expv;
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int fv, r;
    r = int'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(setting == '0 && tuned == '0 && !busy && !done && !burst_req,
        "R1 reset state", int'(setting), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: a stray count while idle moves nothing
    hit_valid = 1'b1; hit_count = HW'(0);
    @(negedge clk);
    hit_valid = 1'b0;
    @(negedge clk);
    chk(setting == '0 && !busy && !burst_req, "R10 count ignored in idle", int'(setting), 0);

    run_tune(1'b1, 20, 0, 1'b0, fv);
    chk(fv == 20, "R7 sharp trim lands on threshold", fv, 20);
    run_tune(1'b1, 40, 0, 1'b0, fv);
    chk(fv == 31, "R8 clamp at trim maximum", fv, 31);
    run_tune(1'b1, 0, 0, 1'b0, fv);
    chk(fv == 0, "R8 clamp at zero", fv, 0);
    run_tune(1'b0, 9000, 0, 1'b0, fv);
    chk(fv == 8191, "R8 clamp at global maximum", fv, 8191);
    run_tune(1'b0, 3000, 0, 1'b0, fv);
    chk(fv == 3000, "R2 global coarse/fine search", fv, 3000);
    run_tune(1'b0, 0, 2, 1'b0, fv);
    chk(fv == 4096, "R6 half every time keeps midpoint", fv, 4096);
    run_tune(1'b1, 11, 0, 1'b1, fv);
    chk(fv == 11, "R10 start while busy ignored", fv, 11);

    for (int k = 0; k < 12; k++) begin
      bit tm;
      int th;
      tm = ($urandom % 2) == 1;
      th = tm ? int'($urandom % 32) : int'($urandom % 8192);
      run_tune(tm, th, 1, k == 5, fv);
      chk(fv == th, "R7 random-count search converges", fv, th);
    end

    // R10: after the run, a count while idle leaves setting and tuned alone
    hit_valid = 1'b1; hit_count = HW'(INJ);
    @(negedge clk);
    hit_valid = 1'b0;
    @(negedge clk);
    chk(setting == tuned && !busy && !done, "R10 idle count after run", int'(setting), int'(tuned));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule